// File: doc/BRIEF.md
# Converter Bank Write Sequencer

This block sits on the host side of a group of double-buffered digital-to-analog converter front ends. Every converter is wired to the same strobe and the same data bus. Each converter also has its own active-low load select and a shared active-low commit select. A host posts one write at a time: an address, a data word and a request level. The sequencer decodes the address and then plays out a slow-peripheral write cycle toward the converters. That cycle has a setup cycle, a strobe-low window of guaranteed minimum width, and a hold window during which data and selects stay put after the strobe rises. The acknowledge comes only after all three.

A converter address loads that converter's first-stage register. The single commit address strobes the commit select of every converter at once, so all outputs change together. A normal update is therefore several load writes followed by one commit write. An address outside both ranges completes at once with an acknowledge and no bus activity. The strobe width and hold length are parameters in nanoseconds. They are turned into whole clock cycles, rounded up, using the clock period parameter.

Top module: `dacwr_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `wr_n`, `xfer_n` and every bit of `cs_n` are 1, `req_ack` is 0 and `dac_data` is 0. An active reset in the middle of a write returns the outputs to this state at once.
- R2: A request is accepted on a rising clock edge in the idle state. When its address is `BASE_ADDR + i` for `i` in `0..N_CONV-1`, `cs_n[i]` goes low in the cycle after acceptance while the other `cs_n` bits and `xfer_n` stay high. It stays low until the acknowledge cycle.
- R3: A request whose address equals `XFER_ADDR` drives `xfer_n` low with all `cs_n` bits high, over the same window as R2.
- R4: For a matched address, `wr_n` stays high for the first cycle after acceptance. It then stays low for exactly `ceil(STROBE_NS / CLK_NS)` consecutive cycles (113 at the defaults).
- R5: After `wr_n` rises, `dac_data` (the captured request data) and the active select stay unchanged for `ceil(HOLD_NS / CLK_NS)` cycles (7 at the defaults). `dac_data` also holds the captured value throughout the setup and strobe cycles.
- R6: `req_ack` is a single-cycle pulse in the cycle after the hold window. The selects return high in that same cycle, and `dac_data` keeps its value.
- R7: While a write is in progress, changes on `req_addr` and `req_data` have no effect on any output, and no new request is accepted before the acknowledge.
- R8: A request whose address matches neither a converter nor `XFER_ADDR` raises `req_ack` in the cycle after acceptance. It drives no select and no strobe, and it leaves `dac_data` at its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host write request, held until acknowledged |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| cs_n | output | N_CONV | Per-converter load select, active low |
| xfer_n | output | 1 | Shared commit select, active low |
| wr_n | output | 1 | Shared write strobe, active low |
| dac_data | output | DATA_W | Data bus toward the converters |

## Verification
Every result has a fixed offset from the acceptance edge, counted in cycles. The selects and data appear 1 cycle later, and the strobe falls 2 cycles later. The strobe rises `S+2` cycles after acceptance and the acknowledge follows `S+H+2` cycles after it, where `S` and `H` are the rounded-up cycle counts. An unmatched address is acknowledged 1 cycle after acceptance. The bench works out `S` and `H` from the nanosecond figures on its own. After each request it samples every cycle at the falling clock edge and compares the whole output bundle against the value that cycle offset should carry.

// File: rtl/dacwr_pkg.sv
package dacwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_ACK
  } wr_state_e;

  // whole cycles needed to cover a nanosecond minimum, rounded up
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacwr_decode.sv
module dacwr_decode #(
  parameter int N_CONV    = 4,
  parameter int ADDR_W    = 4,
  parameter int BASE_ADDR = 2,
  parameter int XFER_ADDR = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_CONV-1:0] hit_conv,
  output logic              hit_xfer,
  output logic              hit_any
);

  localparam logic [ADDR_W-1:0] XFER_A = ADDR_W'(XFER_ADDR);

  for (genvar i = 0; i < N_CONV; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(BASE_ADDR + i);
    assign hit_conv[i] = (addr == SLOT_A);
  end

  assign hit_xfer = (addr == XFER_A) && (hit_conv == '0);
  assign hit_any  = hit_xfer || (hit_conv != '0);

  always_comb begin
    assert ($onehot0({hit_conv, hit_xfer}))
      else $error("p_decode_unique_r2: address hits more than one target");
  end

endmodule

// File: rtl/dacwr_timer.sv
module dacwr_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_max_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      load_max_q <= '0;
    end else if (load) begin
      cnt_q      <= load_val;
      load_max_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  p_timer_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= load_max_q)
    else $error("p_timer_bound_r4: counter above its loaded value");

  p_timer_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1))
    else $error("p_timer_down_r4: counter did not step down");

endmodule

// File: rtl/dacwr_seq.sv
module dacwr_seq
  import dacwr_pkg::*;
#(
  parameter int N_CONV     = 4,
  parameter int DATA_W     = 8,
  parameter int STROBE_CYC = 113,
  parameter int HOLD_CYC   = 7,
  parameter int CNT_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DATA_W-1:0] req_data,
  input  logic [N_CONV-1:0] hit_conv,
  input  logic              hit_xfer,
  input  logic              hit_any,
  input  logic              t_expired,
  output logic              t_load,
  output logic [CNT_W-1:0]  t_val,
  output logic              ack,
  output logic [N_CONV-1:0] sel_conv,
  output logic              sel_xfer,
  output logic              strobe,
  output logic [DATA_W-1:0] data_out
);

  localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);

  wr_state_e         state_q;
  logic              ack_q, strobe_q, xf_q;
  logic [N_CONV-1:0] cs_q;
  logic [DATA_W-1:0] data_q;

  // named internal events
  logic ev_accept, ev_miss, ev_strobe_fall, ev_strobe_rise, ev_hold_done;
  assign ev_accept      = (state_q == ST_IDLE) && req_valid && hit_any;
  assign ev_miss        = (state_q == ST_IDLE) && req_valid && !hit_any;
  assign ev_strobe_fall = (state_q == ST_SETUP);
  assign ev_strobe_rise = (state_q == ST_STROBE) && t_expired;
  assign ev_hold_done   = (state_q == ST_HOLD) && t_expired;

  assign t_load = ev_strobe_fall || ev_strobe_rise;
  assign t_val  = ev_strobe_fall ? STROBE_LD : HOLD_LD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ack_q    <= 1'b0;
      strobe_q <= 1'b0;
      xf_q     <= 1'b0;
      cs_q     <= '0;
      data_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          ack_q <= 1'b0;
          if (ev_accept) begin
            cs_q    <= hit_conv;
            xf_q    <= hit_xfer;
            data_q  <= req_data;
            state_q <= ST_SETUP;
          end else if (ev_miss) begin
            ack_q   <= 1'b1;
            state_q <= ST_ACK;
          end
        end
        ST_SETUP: begin
          strobe_q <= 1'b1;
          state_q  <= ST_STROBE;
        end
        ST_STROBE: begin
          if (ev_strobe_rise) begin
            strobe_q <= 1'b0;
            state_q  <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (ev_hold_done) begin
            cs_q    <= '0;
            xf_q    <= 1'b0;
            ack_q   <= 1'b1;
            state_q <= ST_ACK;
          end
        end
        ST_ACK: begin
          ack_q   <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ack      = ack_q;
  assign sel_conv = cs_q;
  assign sel_xfer = xf_q;
  assign strobe   = strobe_q;
  assign data_out = data_q;

  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STROBE || state_q == ST_HOLD) |=> $stable(data_q))
    else $error("p_data_stable_r5: data moved during strobe or hold");

  p_sel_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_q) |-> ({cs_q, xf_q} != '0))
    else $error("p_sel_held_r5: select dropped when strobe rose");

  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q)
    else $error("p_ack_pulse_r6: acknowledge longer than one cycle");

  p_ack_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (!strobe_q && cs_q == '0 && !xf_q))
    else $error("p_ack_quiet_r8: bus active during acknowledge");

  p_busy_no_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_ACK) |=> (state_q != ST_IDLE))
    else $error("p_busy_no_accept_r7: cycle ended without acknowledge");

endmodule

// File: rtl/dacwr_ctrl.sv
module dacwr_ctrl
  import dacwr_pkg::*;
#(
  parameter int N_CONV    = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 8,
  parameter int STROBE_NS = 900,
  parameter int HOLD_NS   = 50,
  parameter int BASE_ADDR = 2,
  parameter int XFER_ADDR = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ack,
  output logic [N_CONV-1:0] cs_n,
  output logic              xfer_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] dac_data
);

  localparam int STROBE_CYC = int'(ns_to_cycles(STROBE_NS, CLK_NS));
  localparam int HOLD_CYC   = int'(ns_to_cycles(HOLD_NS, CLK_NS));
  localparam int CNT_W      = $clog2(int'(max2(STROBE_CYC, HOLD_CYC)) + 1);

  logic [N_CONV-1:0] hit_conv, sel_conv;
  logic              hit_xfer, hit_any, sel_xfer, strobe;
  logic              t_load, t_expired;
  logic [CNT_W-1:0]  t_val;

  dacwr_decode #(
    .N_CONV(N_CONV), .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR), .XFER_ADDR(XFER_ADDR)
  ) u_decode (
    .addr(req_addr), .hit_conv(hit_conv), .hit_xfer(hit_xfer), .hit_any(hit_any)
  );

  dacwr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_expired)
  );

  dacwr_seq #(
    .N_CONV(N_CONV), .DATA_W(DATA_W),
    .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
    .hit_conv(hit_conv), .hit_xfer(hit_xfer), .hit_any(hit_any),
    .t_expired(t_expired), .t_load(t_load), .t_val(t_val),
    .ack(req_ack), .sel_conv(sel_conv), .sel_xfer(sel_xfer),
    .strobe(strobe), .data_out(dac_data)
  );

  assign cs_n   = ~sel_conv;
  assign xfer_n = ~sel_xfer;
  assign wr_n   = ~strobe;

  p_strobe_one_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ($countones({~cs_n, ~xfer_n}) == 1))
    else $error("p_strobe_one_sel_r2: strobe without exactly one select");

  p_sel_before_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> $past({~cs_n, ~xfer_n} != '0))
    else $error("p_sel_before_strobe_r4: strobe fell with no setup cycle");

endmodule

// File: tb/dacwr_ctrl_bench.sv
module dacwr_ctrl_bench;

  localparam int N   = 4;
  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int BASE = 2;
  localparam int XF   = 12;
  localparam int S = (900 + 8 - 1) / 8;  // strobe cycles
  localparam int H = (50 + 8 - 1) / 8;   // hold cycles
  localparam int NV = 10;
  localparam logic [11:0] VEC [0:NV-1] = '{
    12'h2A5, 12'h33C, 12'h4FF, 12'h500, 12'hC77,
    12'h011, 12'h922, 12'h381, 12'hC00, 12'hFEE
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ack, xfer_n, wr_n;
  logic [N-1:0] cs_n;
  logic [DW-1:0] dac_data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [DW-1:0] last_data = '0;

  always #4 clk = ~clk;

  dacwr_ctrl u_dacwr_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_ack(req_ack), .cs_n(cs_n), .xfer_n(xfer_n),
    .wr_n(wr_n), .dac_data(dac_data)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] bundle(input logic w, input logic x,
                                         input logic [N-1:0] c, input logic a,
                                         input logic [DW-1:0] d);
    return {16'h0, 3'b0, w, x, c, a, d};
  endfunction

  task automatic run_req(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit mutate);
    logic [N-1:0] cs_act;
    logic xf_act, hit;
    int last;
    cs_act = '1; xf_act = 1'b1; hit = 1'b0;
    if (int'(a) >= BASE && int'(a) < BASE + N) begin
      cs_act = ~(N'(1) << (int'(a) - BASE)); hit = 1'b1;
    end else if (int'(a) == XF) begin
      xf_act = 1'b0; hit = 1'b1;
    end
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    last = hit ? S + H + 2 : 1;
    for (int j = 1; j <= last; j++) begin
      logic ew, ea;
      logic [N-1:0] ec;
      logic ex;
      logic [DW-1:0] ed;
      string tag;
      @(negedge clk);
      if (!hit) begin
        ew = 1; ec = '1; ex = 1; ea = 1; ed = last_data; tag = "R8";
      end else begin
        ed = d;
        ew = (j >= 2 && j <= S + 1) ? 1'b0 : 1'b1;
        ea = (j == last);
        ec = ea ? '1 : cs_act;
        ex = ea ? 1'b1 : xf_act;
        if (j == 1) tag = (int'(a) == XF) ? "R3" : "R2";
        else if (j <= S + 1) tag = "R4";
        else if (j < last) tag = "R5";
        else tag = "R6";
        if (mutate && j > 40 && j < last) tag = "R7";
      end
      check(bundle(wr_n, xfer_n, cs_n, req_ack, dac_data) == bundle(ew, ex, ec, ea, ed),
            tag, bundle(wr_n, xfer_n, cs_n, req_ack, dac_data),
            bundle(ew, ex, ec, ea, ed));
      if (mutate && j == 40) begin
        req_addr = AW'(XF); req_data = ~d;
      end
    end
    req_valid = 1'b0;
    if (hit) last_data = d;
  endtask

  initial begin : watchdog
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    fails++;
    $display("FAIL watchdog: run hung, got %0d expected <150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bundle(wr_n, xfer_n, cs_n, req_ack, dac_data) == bundle(1, 1, '1, 0, 0),
          "R1", bundle(wr_n, xfer_n, cs_n, req_ack, dac_data), bundle(1, 1, '1, 0, 0));
    rst_n = 1'b1;
    @(negedge clk);
    check(bundle(wr_n, xfer_n, cs_n, req_ack, dac_data) == bundle(1, 1, '1, 0, 0),
          "R1", bundle(wr_n, xfer_n, cs_n, req_ack, dac_data), bundle(1, 1, '1, 0, 0));

    // table walk: loads, broadcast commit, misses
    for (int v = 0; v < NV; v++) begin
      run_req(VEC[v][11:8], VEC[v][7:0], 1'b0);
    end

    // R7: address and data change mid-write
    run_req(4'h4, 8'h5A, 1'b1);
    run_req(4'hC, 8'h96, 1'b1);

    // R8 right after a matched write keeps last data
    run_req(4'h1, 8'hC3, 1'b0);

    // R1: reset in the middle of a strobe
    @(negedge clk);
    req_valid = 1'b1; req_addr = 4'h3; req_data = 8'hE1;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    #1;
    check(bundle(wr_n, xfer_n, cs_n, req_ack, dac_data) == bundle(1, 1, '1, 0, 0),
          "R1", bundle(wr_n, xfer_n, cs_n, req_ack, dac_data), bundle(1, 1, '1, 0, 0));
    @(negedge clk);
    rst_n = 1'b1;
    last_data = '0;
    run_req(4'h5, 8'h3F, 1'b0);
    run_req(4'hC, 8'h01, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule